// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block holds a small bank of lock flags shared by two independent ports, left and right. It sits next to a two-sided shared memory so that software on each side can agree on who currently owns a shared region. A port asks for a flag by writing to it, then reads the flag back to find out whether it got it. A request that cannot be granted at once is remembered. It is granted automatically when the current holder lets go.

Each port has an active-low chip enable, an active-low semaphore enable, a read/write select, an active-low output enable, a flag address and a data bus. A semaphore access is recognised only when the semaphore enable is low and the memory chip enable is high. Both ports run from one clock with an active-low asynchronous reset. Read data comes back registered, with a one-cycle valid strobe.

Top module: `dp_sema_unit`

## Requirements
- R1: After reset every flag is free. Neither valid strobe is high, and a read of any flag from either port returns 8'hFF.
- R2: A port performs a semaphore access only when its semaphore enable is low and its chip enable is high. With chip enable low (alone or together with semaphore enable low) the port changes no flag and produces no read valid.
- R3: A write (read/write low) uses data bit 0 only: 0 requests the addressed flag and 1 releases it. Bits 7..1 have no effect.
- R4: A request on a free flag makes the requesting port its owner from the next cycle. A read returns 8'h00 to the owner and 8'hFF to the other port.
- R5: There are NUM_FLAGS (default 8) independent flags, selected by the low address bits. An action on one flag leaves every other flag unchanged.
- R6: A request on a flag owned by the other port stays pending, and the read from the requester returns 8'hFF. When the owner releases the flag, the pending port becomes owner in the same update.
- R7: When both ports request the same free flag in the same cycle, the left port becomes owner and the right request stays pending.
- R8: A release written by a port that does not own the flag clears only that port's pending request. The owner does not change.
- R9: A read needs read/write high and output enable low. Data and valid appear on the port one cycle after the access, and valid stays low for any cycle that follows no read.
- R10: A flag is never owned by both ports at once, and a valid read returns only 8'h00 or 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_ce_ni | input | 1 | Left memory chip enable, active low |
| l_sem_ni | input | 1 | Left semaphore enable, active low |
| l_rw_i | input | 1 | Left read (1) / write (0) |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_addr_i | input | 3 | Left flag address |
| l_wdata_i | input | 8 | Left write data, bit 0 used |
| l_rdata_o | output | 8 | Left registered read data |
| l_rvalid_o | output | 1 | Left read data valid |
| r_ce_ni | input | 1 | Right memory chip enable, active low |
| r_sem_ni | input | 1 | Right semaphore enable, active low |
| r_rw_i | input | 1 | Right read (1) / write (0) |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_addr_i | input | 3 | Right flag address |
| r_wdata_i | input | 8 | Right write data, bit 0 used |
| r_rdata_o | output | 8 | Right registered read data |
| r_rvalid_o | output | 1 | Right read data valid |

## Verification
An internal fault in this block can stay hidden until a port reads the affected flag. A lost or doubled owner shows up on the very next read as the wrong 8'h00/8'hFF pattern on one side, or as the same pattern on both sides. A dropped pending bit is subtler. It appears only after the owner releases the flag, when the waiting port's read still shows 8'hFF instead of 8'h00. The tests therefore read both ports straight after every release and every tie.

// File: rtl/dp_sema_pkg.sv
package dp_sema_pkg;
  typedef enum logic [1:0] {
    OWN_FREE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int unsigned SIDE_L    = 0;
  localparam int unsigned SIDE_R    = 1;
  localparam int unsigned NUM_SIDES = 2;
endpackage

// File: rtl/dp_sema_port_decode.sv
module dp_sema_port_decode #(
  parameter int unsigned NUM_FLAGS = 8,
  parameter int unsigned ADDR_W    = $clog2(NUM_FLAGS)
) (
  input  logic              ce_ni,
  input  logic              sem_ni,
  input  logic              rw_i,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wbit_i,
  output logic [NUM_FLAGS-1:0] req_o,
  output logic [NUM_FLAGS-1:0] rel_o,
  output logic              rd_o
);
  logic acc, wr;

  // chip enable low blocks the bank, also in the illegal combination
  assign acc  = ce_ni & ~sem_ni;
  assign wr   = acc & ~rw_i;
  assign rd_o = acc & rw_i & ~oe_ni;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_sel
    logic hit;
    assign hit      = wr && (addr_i == ADDR_W'(i));
    assign req_o[i] = hit & ~wbit_i;
    assign rel_o[i] = hit &  wbit_i;
  end
endmodule

// File: rtl/dp_sema_flag_cell.sv
module dp_sema_flag_cell
  import dp_sema_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_l_i,
  input  logic rel_l_i,
  input  logic req_r_i,
  input  logic rel_r_i,
  output logic own_l_o,
  output logic own_r_o,
  output logic pend_l_o,
  output logic pend_r_o
);
  owner_e own_q, own_d;
  logic   pl_q, pr_q, pl_d, pr_d;

  always_comb begin
    own_d = own_q;
    pl_d  = pl_q;
    pr_d  = pr_q;
    // releases first, so a hand-over and a new request resolve in one update
    if (rel_l_i) begin
      if (own_d == OWN_LEFT) own_d = OWN_FREE;
      else                   pl_d  = 1'b0;
    end
    if (rel_r_i) begin
      if (own_d == OWN_RIGHT) own_d = OWN_FREE;
      else                    pr_d  = 1'b0;
    end
    if (req_l_i && own_d != OWN_LEFT)  pl_d = 1'b1;
    if (req_r_i && own_d != OWN_RIGHT) pr_d = 1'b1;
    // fixed tie-break: left first
    if (own_d == OWN_FREE) begin
      if (pl_d) begin
        own_d = OWN_LEFT;
        pl_d  = 1'b0;
      end else if (pr_d) begin
        own_d = OWN_RIGHT;
        pr_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q <= OWN_FREE;
      pl_q  <= 1'b0;
      pr_q  <= 1'b0;
    end else begin
      own_q <= own_d;
      pl_q  <= pl_d;
      pr_q  <= pr_d;
    end
  end

  assign own_l_o  = (own_q == OWN_LEFT);
  assign own_r_o  = (own_q == OWN_RIGHT);
  assign pend_l_o = pl_q;
  assign pend_r_o = pr_q;
endmodule

// File: rtl/dp_sema_readback.sv
module dp_sema_readback #(
  parameter int unsigned NUM_FLAGS = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = $clog2(NUM_FLAGS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_FLAGS-1:0] own_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '1;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= {DATA_W{~own_i[addr_i]}};
    end
  end
endmodule

// File: rtl/dp_sema_unit.sv
module dp_sema_unit
  import dp_sema_pkg::*;
#(
  parameter int unsigned NUM_FLAGS = 8,
  parameter int unsigned DATA_W    = 8,
  localparam int unsigned ADDR_W   = $clog2(NUM_FLAGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_ce_ni,
  input  logic              l_sem_ni,
  input  logic              l_rw_i,
  input  logic              l_oe_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic              l_rvalid_o,
  input  logic              r_ce_ni,
  input  logic              r_sem_ni,
  input  logic              r_rw_i,
  input  logic              r_oe_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic              r_rvalid_o
);
  logic [NUM_SIDES-1:0]              ce_n, sem_n, rw, oe_n, wbit, rd;
  logic [NUM_SIDES-1:0][ADDR_W-1:0]  addr;
  logic [NUM_SIDES-1:0][DATA_W-1:0]  rdata;
  logic [NUM_SIDES-1:0]              rvalid;
  logic [NUM_SIDES-1:0][NUM_FLAGS-1:0] req, rel, own, pend;
  logic [NUM_FLAGS-1:0] own_l_vec, own_r_vec, pend_l_vec, pend_r_vec;
  logic unused_wdata_hi;

  assign ce_n  = {r_ce_ni,  l_ce_ni};
  assign sem_n = {r_sem_ni, l_sem_ni};
  assign rw    = {r_rw_i,   l_rw_i};
  assign oe_n  = {r_oe_ni,  l_oe_ni};
  assign addr  = {r_addr_i, l_addr_i};
  assign wbit  = {r_wdata_i[0], l_wdata_i[0]};
  assign unused_wdata_hi = ^{l_wdata_i[DATA_W-1:1], r_wdata_i[DATA_W-1:1]};

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    dp_sema_port_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_dec (
      .ce_ni (ce_n[s]),
      .sem_ni(sem_n[s]),
      .rw_i  (rw[s]),
      .oe_ni (oe_n[s]),
      .addr_i(addr[s]),
      .wbit_i(wbit[s]),
      .req_o (req[s]),
      .rel_o (rel[s]),
      .rd_o  (rd[s])
    );
    dp_sema_readback #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rd_i    (rd[s]),
      .addr_i  (addr[s]),
      .own_i   (own[s]),
      .rdata_o (rdata[s]),
      .rvalid_o(rvalid[s])
    );
  end

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    dp_sema_flag_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_l_i (req[SIDE_L][f]),
      .rel_l_i (rel[SIDE_L][f]),
      .req_r_i (req[SIDE_R][f]),
      .rel_r_i (rel[SIDE_R][f]),
      .own_l_o (own[SIDE_L][f]),
      .own_r_o (own[SIDE_R][f]),
      .pend_l_o(pend[SIDE_L][f]),
      .pend_r_o(pend[SIDE_R][f])
    );
  end

  assign own_l_vec  = own[SIDE_L];
  assign own_r_vec  = own[SIDE_R];
  assign pend_l_vec = pend[SIDE_L];
  assign pend_r_vec = pend[SIDE_R];

  assign l_rdata_o  = rdata[SIDE_L];
  assign l_rvalid_o = rvalid[SIDE_L];
  assign r_rdata_o  = rdata[SIDE_R];
  assign r_rvalid_o = rvalid[SIDE_R];
endmodule

// File: rtl/dp_sema_sva.sv
module dp_sema_sva #(
  parameter int unsigned NUM_FLAGS = 8,
  parameter int unsigned DATA_W    = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 l_ce_ni,
  input logic                 l_sem_ni,
  input logic                 l_rw_i,
  input logic                 l_oe_ni,
  input logic                 r_ce_ni,
  input logic                 r_sem_ni,
  input logic                 r_rw_i,
  input logic                 r_oe_ni,
  input logic [DATA_W-1:0]    l_rdata_o,
  input logic                 l_rvalid_o,
  input logic [DATA_W-1:0]    r_rdata_o,
  input logic                 r_rvalid_o,
  input logic [NUM_FLAGS-1:0] own_l_vec,
  input logic [NUM_FLAGS-1:0] own_r_vec,
  input logic [NUM_FLAGS-1:0] pend_l_vec,
  input logic [NUM_FLAGS-1:0] pend_r_vec
);
  logic l_rd, r_rd;
  assign l_rd = l_ce_ni && !l_sem_ni && l_rw_i && !l_oe_ni;
  assign r_rd = r_ce_ni && !r_sem_ni && r_rw_i && !r_oe_ni;

  a_r10_single_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_l_vec & own_r_vec) == '0);

  a_r6_pending_needs_other_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_l_vec & ~own_r_vec) == '0) && ((pend_r_vec & ~own_l_vec) == '0));

  a_r2_blocked_left_no_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_ce_ni && r_sem_ni) |=> ($stable(own_l_vec) && $stable(own_r_vec)
                                && $stable(pend_l_vec) && $stable(pend_r_vec)));

  a_r9_left_valid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_rd |=> l_rvalid_o);
  a_r9_left_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l_rd |=> !l_rvalid_o);
  a_r9_right_valid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_rd |=> r_rvalid_o);
  a_r9_right_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_rd |=> !r_rvalid_o);

  a_r10_left_rdata_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_rvalid_o |-> (l_rdata_o == '0 || l_rdata_o == '1));
  a_r10_right_rdata_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_rvalid_o |-> (r_rdata_o == '0 || r_rdata_o == '1));
endmodule

bind dp_sema_unit dp_sema_sva #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .l_ce_ni   (l_ce_ni),
  .l_sem_ni  (l_sem_ni),
  .l_rw_i    (l_rw_i),
  .l_oe_ni   (l_oe_ni),
  .r_ce_ni   (r_ce_ni),
  .r_sem_ni  (r_sem_ni),
  .r_rw_i    (r_rw_i),
  .r_oe_ni   (r_oe_ni),
  .l_rdata_o (l_rdata_o),
  .l_rvalid_o(l_rvalid_o),
  .r_rdata_o (r_rdata_o),
  .r_rvalid_o(r_rvalid_o),
  .own_l_vec (own_l_vec),
  .own_r_vec (own_r_vec),
  .pend_l_vec(pend_l_vec),
  .pend_r_vec(pend_r_vec)
);

// File: tb/sim_dp_sema_unit.sv
`timescale 1ns/1ps
module sim_dp_sema_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       l_ce_n, l_sem_n, l_rw, l_oe_n, r_ce_n, r_sem_n, r_rw, r_oe_n;
  logic [2:0] l_addr, r_addr;
  logic [7:0] l_wd, r_wd, l_rd, r_rd;
  logic       l_rv, r_rv;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  dp_sema_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .l_ce_ni(l_ce_n), .l_sem_ni(l_sem_n), .l_rw_i(l_rw), .l_oe_ni(l_oe_n),
    .l_addr_i(l_addr), .l_wdata_i(l_wd), .l_rdata_o(l_rd), .l_rvalid_o(l_rv),
    .r_ce_ni(r_ce_n), .r_sem_ni(r_sem_n), .r_rw_i(r_rw), .r_oe_ni(r_oe_n),
    .r_addr_i(r_addr), .r_wdata_i(r_wd), .r_rdata_o(r_rd), .r_rvalid_o(r_rv)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    l_ce_n = 1; l_sem_n = 1; l_rw = 1; l_oe_n = 1; l_addr = 0; l_wd = 8'h00;
    r_ce_n = 1; r_sem_n = 1; r_rw = 1; r_oe_n = 1; r_addr = 0; r_wd = 8'h00;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_wr(input bit right, input logic [2:0] a, input logic [7:0] d);
    if (right) begin r_sem_n = 0; r_rw = 0; r_addr = a; r_wd = d; end
    else       begin l_sem_n = 0; l_rw = 0; l_addr = a; l_wd = d; end
  endtask

  task automatic set_rd(input bit right, input logic [2:0] a);
    if (right) begin r_sem_n = 0; r_rw = 1; r_oe_n = 0; r_addr = a; end
    else       begin l_sem_n = 0; l_rw = 1; l_oe_n = 0; l_addr = a; end
  endtask

  task automatic wr1(input bit right, input logic [2:0] a, input logic [7:0] d);
    idle(); set_wr(right, a, d); tick(); idle();
  endtask

  // read same flag from both ports in one cycle
  task automatic rd2(input logic [2:0] a, input logic [7:0] el, input logic [7:0] er,
                     input string req);
    idle(); set_rd(0, a); set_rd(1, a); tick(); idle();
    check({req, " left valid"}, {7'd0, l_rv}, 8'd1);
    check({req, " right valid"}, {7'd0, r_rv}, 8'd1);
    check({req, " left data"}, l_rd, el);
    check({req, " right data"}, r_rd, er);
  endtask

  task automatic t_reset();
    check("R1 left valid low", {7'd0, l_rv}, 8'd0);
    check("R1 right valid low", {7'd0, r_rv}, 8'd0);
    for (int i = 0; i < 8; i++) rd2(3'(i), 8'hFF, 8'hFF, "R1 free after reset");
  endtask

  task automatic t_grant();
    wr1(0, 3'd2, 8'hFE);                 // R3: upper bits set, bit0=0 -> request
    rd2(3'd2, 8'h00, 8'hFF, "R4 left owns flag 2");
    rd2(3'd3, 8'hFF, 8'hFF, "R5 flag 3 untouched");
    wr1(1, 3'd4, 8'h00);
    rd2(3'd4, 8'hFF, 8'h00, "R5 right owns flag 4");
    rd2(3'd2, 8'h00, 8'hFF, "R5 flag 2 kept");
  endtask

  task automatic t_pending();
    wr1(1, 3'd2, 8'h00);                 // right waits on left's flag 2
    rd2(3'd2, 8'h00, 8'hFF, "R6 right pending");
    wr1(0, 3'd2, 8'h01);                 // R3: bit0=1 release
    rd2(3'd2, 8'hFF, 8'h00, "R6 hand-over to right");
    wr1(1, 3'd2, 8'hFF);
    wr1(1, 3'd4, 8'h01);
    rd2(3'd2, 8'hFF, 8'hFF, "R3 release clears flag 2");
    rd2(3'd4, 8'hFF, 8'hFF, "R3 release clears flag 4");
  endtask

  task automatic t_tie();
    idle(); set_wr(0, 3'd6, 8'h00); set_wr(1, 3'd6, 8'h00); tick(); idle();
    rd2(3'd6, 8'h00, 8'hFF, "R7 left wins tie");
    wr1(0, 3'd6, 8'h01);
    rd2(3'd6, 8'hFF, 8'h00, "R7 right pending granted");
    wr1(1, 3'd6, 8'h01);
    rd2(3'd6, 8'hFF, 8'hFF, "R10 flag 6 free");
  endtask

  task automatic t_nonowner();
    wr1(1, 3'd1, 8'h00);
    wr1(0, 3'd1, 8'h00);                 // left pending
    wr1(0, 3'd1, 8'h01);                 // cancel own pending
    rd2(3'd1, 8'hFF, 8'h00, "R8 owner unchanged");
    wr1(1, 3'd1, 8'h01);
    rd2(3'd1, 8'hFF, 8'hFF, "R8 cancelled request not granted");
  endtask

  task automatic t_blocked();
    idle(); l_ce_n = 0; set_wr(0, 3'd0, 8'h00); tick(); idle();
    rd2(3'd0, 8'hFF, 8'hFF, "R2 ce+sem write ignored");
    idle(); r_ce_n = 0; r_sem_n = 1; r_rw = 0; r_addr = 3'd0; r_wd = 8'h00; tick(); idle();
    rd2(3'd0, 8'hFF, 8'hFF, "R2 memory write ignored");
    idle(); l_ce_n = 0; set_rd(0, 3'd0); tick(); idle();
    check("R2 ce+sem read no valid", {7'd0, l_rv}, 8'd0);
  endtask

  task automatic t_read_gate();
    wr1(0, 3'd7, 8'h00);
    idle(); set_rd(0, 3'd7); l_oe_n = 1; tick(); idle();
    check("R9 oe high no valid", {7'd0, l_rv}, 8'd0);
    idle(); set_rd(0, 3'd7); tick(); idle();
    check("R9 valid after read", {7'd0, l_rv}, 8'd1);
    check("R9 data", l_rd, 8'h00);
    tick();
    check("R9 valid drops", {7'd0, l_rv}, 8'd0);
    check("R9 data held", l_rd, 8'h00);
    wr1(0, 3'd7, 8'h01);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_grant();
    t_pending();
    t_tie();
    t_nonowner();
    t_blocked();
    t_read_gate();
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule